// File: doc/BRIEF.md
# Dual Edge-Qualified Binary Counter

Two independent 4-bit binary up-counters live in one block and share nothing but the system clock and the system reset. Each counter has two external count inputs. One input advances the count when it goes from low to high, but only while the other input is low. The other input advances the count when it goes from high to low, but only while the first input is high. Either input can therefore be wired as the clock, with the other acting as a level enable. Each counter also has its own clear input, which is active high and asynchronous.

The count inputs are not treated as clocks. They are brought into the system clock domain through a two-flop synchronizer. The block then forms a single gate level from them: the rising input high and the falling input low. A low-to-high change of that gate level gives a one-cycle count pulse. Every bit of a counter's state updates on the same system clock edge. Bit 0 toggles on every count. A higher bit toggles only when every bit below it is 1.

Top module: `dual_sync_counter`

## Requirements
- R1: The two counters are independent. Inputs on one channel never change the other channel's count.
- R2: A low-to-high change of `rise_in[c]` while `fall_in[c]` is low increments counter c by exactly one.
- R3: A high-to-low change of `fall_in[c]` while `rise_in[c]` is high increments counter c by exactly one.
- R4: A change of `rise_in[c]` while `fall_in[c]` is high has no effect on the count. A change of `fall_in[c]` while `rise_in[c]` is low also has no effect.
- R5: The count is plain binary and has no terminal-count output. Bit i of channel c is `count_o[4*c+i]`. After 15 the next count is 0.
- R6: While `clr_in[c]` is high, counter c reads 0 at once, without waiting for a clock edge, and ignores all count events. After release it counts up from 0.
- R7: A system reset `rst` that is high on a clock edge sets both counters to 0.
- R8: A qualifying input change applied between clock edges appears on `count_o` after the third following rising edge of `clk`, and not earlier.
- R9: If `rise_in[c]` goes high and `fall_in[c]` goes low in the same cycle, counter c advances by exactly one.
- R10: Inputs held at a constant level produce no further counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| rise_in | input | 2 | Per-channel input that counts on its rising edge |
| fall_in | input | 2 | Per-channel input that counts on its falling edge |
| clr_in | input | 2 | Per-channel asynchronous active-high clear |
| count_o | output | 8 | Channel c count at bits [4c+3:4c] |

## Verification
For each channel, the bench drives every pair of successive input levels: 16 transitions of the two inputs. A design that treated the two inputs as separate edge sources would count twice on the simultaneous transition, or would count an edge while its partner input is disabled. Long runs with the rising input as clock, and then with the falling input as clock, pass through the 15-to-0 wrap. These runs catch a carry chain that drops or repeats a bit. The bench asserts the clear between clock edges and requires a zero count before the next edge arrives, which exposes a clear that only acts on the clock. It also checks the exact latency cycle, so a missing or extra synchronizer stage shows up as a count one cycle early or late.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int CNT_W        = 4;
    localparam int NUM_CH       = 2;
    localparam int SYNC_STAGES  = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } cnt_in_t;

    // Level that opens the count path: rising input high, falling input low.
    function automatic logic gate_level(cnt_in_t s);
        return s.rise & ~s.fall;
    endfunction

endpackage

// File: rtl/dsc_sync.sv
module dsc_sync
    import dsc_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic    clk,
    input  logic    rst,
    input  cnt_in_t d_i,
    output cnt_in_t q_o
);

    cnt_in_t stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d_i;
    end

    genvar i;
    generate
        for (i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else     stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/dsc_edge_qual.sv
module dsc_edge_qual
    import dsc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  cnt_in_t s_i,
    output logic    pulse_o
);

    logic gate_now;
    logic gate_q;

    assign gate_now = gate_level(s_i);

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_now;
    end

    assign pulse_o = gate_now & ~gate_q;

    // A qualified edge gives one pulse, never a run of pulses (R10).
    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        pulse_o |=> !pulse_o);

    // No pulse while the rising input is low or the falling input is high (R4).
    assert_disabled_no_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        (!s_i.rise || s_i.fall) |-> !pulse_o);

endmodule

// File: rtl/dsc_counter.sv
module dsc_counter
    import dsc_pkg::*;
#(
    parameter int WIDTH = CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             pulse_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH:0]   carry;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] q;

    assign carry[0] = pulse_i;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign carry[i+1] = carry[i] & q[i];
            assign nxt[i]     = q[i] ^ carry[i];
        end
    endgenerate

    always_ff @(posedge clk or posedge clr_i) begin
        if (clr_i)    q <= '0;
        else if (rst) q <= '0;
        else          q <= nxt;
    end

    assign q_o = q;

    // Each pulse adds exactly one, wrapping modulo 2**WIDTH (R5).
    assert_increment_R5: assert property (@(posedge clk) disable iff (rst || clr_i)
        pulse_i |=> q == WIDTH'($past(q) + 1'b1));

    // Without a pulse the count holds (R10).
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst || clr_i)
        !pulse_i |=> $stable(q));

    // Clear keeps the count at zero (R6).
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
        clr_i |-> q == '0);

endmodule

// File: rtl/dual_sync_counter.sv
module dual_sync_counter
    import dsc_pkg::*;
#(
    parameter int NCH   = NUM_CH,
    parameter int WIDTH = CNT_W,
    parameter int SYNC  = SYNC_STAGES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NCH-1:0]       rise_in,
    input  logic [NCH-1:0]       fall_in,
    input  logic [NCH-1:0]       clr_in,
    output logic [NCH*WIDTH-1:0] count_o
);

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            cnt_in_t raw;
            cnt_in_t synced;
            logic    pulse;

            assign raw.rise = rise_in[c];
            assign raw.fall = fall_in[c];

            dsc_sync #(.STAGES(SYNC)) u_sync (
                .clk (clk),
                .rst (rst),
                .d_i (raw),
                .q_o (synced)
            );

            dsc_edge_qual u_qual (
                .clk     (clk),
                .rst     (rst),
                .s_i     (synced),
                .pulse_o (pulse)
            );

            dsc_counter #(.WIDTH(WIDTH)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .clr_i   (clr_in[c]),
                .pulse_i (pulse),
                .q_o     (count_o[c*WIDTH +: WIDTH])
            );
        end
    endgenerate

    // System reset leaves every counter at zero (R7).
    assert_reset_zero_R7: assert property (@(posedge clk)
        rst |=> count_o == '0);

endmodule

// File: tb/dual_sync_counter_tb.sv
module dual_sync_counter_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] rise_in = '0;
    logic [1:0] fall_in = '0;
    logic [1:0] clr_in = '0;
    logic [7:0] count_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0] exp_cnt [2];
    logic       prev_g  [2];

    always #5 clk = ~clk;

    dual_sync_counter u_dut (
        .clk     (clk),
        .rst     (rst),
        .rise_in (rise_in),
        .fall_in (fall_in),
        .clr_in  (clr_in),
        .count_o (count_o)
    );

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic check(int ch, logic [3:0] exp, string req);
        logic [3:0] got;
        got = count_o[ch*4 +: 4];
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s ch%0d got %0d expected %0d", req, ch, got, exp);
        end
    endtask

    // Reference: count when (rise & ~fall) goes from 0 to 1 and clear is low.
    task automatic model(int ch);
        logic g;
        g = rise_in[ch] & ~fall_in[ch];
        if (g && !prev_g[ch] && !clr_in[ch]) exp_cnt[ch] = exp_cnt[ch] + 4'd1;
        prev_g[ch] = g;
    endtask

    task automatic drive(int ch, logic r, logic f, string req);
        @(negedge clk);
        rise_in[ch] = r;
        fall_in[ch] = f;
        model(ch);
        repeat (4) @(posedge clk);
        #2;
        check(ch, exp_cnt[ch], req);
        check(1 - ch, exp_cnt[1 - ch], "R1");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired got running expected finished");
        finish_run();
    end

    initial begin
        exp_cnt[0] = 0; exp_cnt[1] = 0;
        prev_g[0] = 0;  prev_g[1] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(0, 4'd0, "R7");
        check(1, 4'd0, "R7");

        // R8 latency: visible after the third rising edge, not before.
        @(negedge clk);
        rise_in[0] = 1'b1;
        model(0);
        repeat (2) @(posedge clk);
        #2 check(0, 4'd0, "R8");
        @(posedge clk);
        #2 check(0, 4'd1, "R8");
        drive(0, 1'b0, 1'b0, "R2");

        // R2 and R5: rising input as clock, past the 15->0 wrap.
        for (int n = 0; n < 18; n++) begin
            drive(0, 1'b1, 1'b0, "R2");
            drive(0, 1'b0, 1'b0, "R5");
        end
        check(0, 4'd3, "R5");

        // R3 and R5: falling input as clock on channel 1.
        drive(1, 1'b1, 1'b1, "R3");
        for (int n = 0; n < 18; n++) begin
            drive(1, 1'b1, 1'b0, "R3");
            drive(1, 1'b1, 1'b1, "R5");
        end
        check(1, 4'd2, "R5");

        // R4: the disabled edges.
        drive(0, 1'b0, 1'b1, "R4");
        for (int n = 0; n < 4; n++) begin
            drive(0, 1'b1, 1'b1, "R4");
            drive(0, 1'b0, 1'b1, "R4");
        end
        drive(0, 1'b0, 1'b0, "R4");
        for (int n = 0; n < 4; n++) begin
            drive(0, 1'b0, 1'b1, "R4");
            drive(0, 1'b0, 1'b0, "R4");
        end
        check(0, 4'd3, "R4");

        // R9 and more: every pair of successive input levels on both channels.
        for (int ch = 0; ch < 2; ch++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++) begin
                    drive(ch, a[1], a[0], "R2");
                    drive(ch, b[1], b[0], (a == 1 && b == 2) ? "R9" : "R4");
                end

        // R10: steady levels produce nothing more.
        drive(0, 1'b1, 1'b0, "R10");
        repeat (20) @(posedge clk);
        #2 check(0, exp_cnt[0], "R10");

        // R6: clear between edges acts at once and blocks counting.
        drive(0, 1'b0, 1'b0, "R6");
        drive(0, 1'b1, 1'b0, "R6");
        @(negedge clk);
        #2 clr_in[0] = 1'b1;
        exp_cnt[0] = 0;
        #1 check(0, 4'd0, "R6");
        drive(0, 1'b0, 1'b0, "R6");
        drive(0, 1'b1, 1'b0, "R6");
        drive(0, 1'b0, 1'b0, "R6");
        @(negedge clk);
        clr_in[0] = 1'b0;
        drive(0, 1'b1, 1'b0, "R6");
        check(0, 4'd1, "R6");

        // R7: system reset in mid count.
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #2;
        check(0, 4'd0, "R7");
        check(1, 4'd0, "R7");

        finish_run();
    end

endmodule